// File: doc/BRIEF.md
# RC Timing-Pin Wake-Up and Suspend Controller

This block manages one external timing pin that is wired to an RC network, and it controls suspend and resume for a small controller. Software discharges the capacitor by writing 0 to the pin bit of a control register, which turns the open-drain driver on. It then writes 1, which turns the driver off so the capacitor can charge. When the pin input rises past its threshold, which is modelled here as a clean low-to-high transition, the block sets a sticky wake flag. Software clears that flag by writing one to it. Reading the control register returns the live pin level, not the value last written.

While the device is suspended, the block holds its clock-run enable low. The suspend ends on a rising edge of the pin or on a GPIO interrupt. On wake, the clock-run enable returns at once. The core-ready output follows after a fixed number of resonator cycles, set by a parameter; 1536 cycles is 256 µs at 6 MHz. Interrupt servicing stays blocked after wake until the processor retires one instruction, which is the instruction that follows the suspend-entering write.

Top module: `rc_wake_ctrl`

## Requirements
- R1: After reset, `pin_drive_low` is 0, `suspended` is 0, and `clk_run`, `core_ready` and `irq_ok` are 1. The wake flag reads 0. The control register reads 1 while the external pin is high.
- R2: A write to the control address (0x22) drives the pin low from the next cycle when data bit 0 is 0, and releases it when data bit 0 is 1.
- R3: A read of the control address returns the pin level, taken through a two-flop synchronizer, in bit 0. Bits 7 to 1 read 0. `io_rdata` is valid on the cycle after the `io_rd` strobe.
- R4: A low-to-high transition of the synchronized pin sets the wake flag. The flag is visible from the third clock edge after the pin rises, and it reads in bit 0 of the status address (0x24). A falling edge does not set it.
- R5: Writing 1 to bit 0 of the status address clears the wake flag. Writing 0 there leaves it unchanged.
- R6: A `suspend_req` pulse while the device is running causes the following from the next edge: `suspended` goes to 1, and `clk_run`, `core_ready` and `irq_ok` go to 0.
- R7: While the device is suspended, either a `gpio_irq` pulse or a pin rising edge ends suspend on that edge. From then on, `suspended` is 0 and `clk_run` is 1.
- R8: `core_ready` rises exactly READY_CYCLES clock edges after the wake edge, and it is never 1 while the device is suspended.
- R9: After a wake, `irq_ok` stays 0 until `instr_retire` is seen. It rises on that edge.
- R10: A pin rising edge or a GPIO pulse while the device is running does not change `suspended`, `clk_run` or `core_ready`.
- R11: A write to an address other than 0x22 does not change the pin driver.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Resonator-rate clock |
| rst | input | 1 | Synchronous active-high reset |
| io_addr | input | 8 | I/O address |
| io_wr | input | 1 | Write strobe |
| io_rd | input | 1 | Read strobe |
| io_wdata | input | 8 | Write data |
| io_rdata | output | 8 | Read data, registered |
| pin_in | input | 1 | Digital level of the timing pin |
| pin_drive_low | output | 1 | Open-drain enable; 1 pulls the pin low |
| gpio_irq | input | 1 | GPIO interrupt request, used as a wake source |
| suspend_req | input | 1 | Suspend-entering write strobe |
| instr_retire | input | 1 | Pulse when the processor retires an instruction |
| wake_flag | output | 1 | Sticky pin wake interrupt flag |
| suspended | output | 1 | Device is in suspend |
| clk_run | output | 1 | Enable for the oscillator, GPIO and timers |
| core_ready | output | 1 | Rest of the device is fully working |
| irq_ok | output | 1 | Interrupt servicing allowed |

## Verification
The pin input is tried with three patterns: held high, a falling edge, and a rising edge. This shows that only a rising transition sets the flag, and that the read-back follows the pin rather than the written bit. Waking is tried once with a GPIO pulse and once with a pin rise after a discharge and release. Each source is checked on its own to end suspend, and the pin wake is checked to take the two synchronizer cycles first. The ready output is sampled one edge before and on the edge where the count ends, so a count that is off by one edge in either direction is caught. The same edge patterns are then applied while the device is running, to confirm that they leave the power state alone.

// File: rtl/rcw_pkg.sv
package rcw_pkg;
  typedef enum logic [1:0] {
    PWR_RUN  = 2'd0,
    PWR_SUSP = 2'd1,
    PWR_WARM = 2'd2
  } pwr_state_t;
endpackage

// File: rtl/rcw_sync_edge.sv
module rcw_sync_edge #(
  parameter int   STAGES    = 2,
  parameter logic RESET_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic async_in,
  output logic level,
  output logic rise
);
  logic [STAGES-1:0] chain;
  logic              last;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk) begin
        if (rst) chain <= RESET_VAL;
        else     chain <= async_in;
      end
    end else begin : g_many
      always_ff @(posedge clk) begin
        if (rst) chain <= {STAGES{RESET_VAL}};
        else     chain <= {chain[STAGES-2:0], async_in};
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) last <= RESET_VAL;
    else     last <= chain[STAGES-1];
  end

  assign level = chain[STAGES-1];
  assign rise  = chain[STAGES-1] & ~last;
endmodule

// File: rtl/rcw_pin_reg.sv
module rcw_pin_reg #(
  parameter int               ADDR_W    = 8,
  parameter int               DATA_W    = 8,
  parameter logic [ADDR_W-1:0] CTRL_ADDR = 8'h22,
  parameter logic [ADDR_W-1:0] STAT_ADDR = 8'h24
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] io_addr,
  input  logic              io_wr,
  input  logic              io_rd,
  input  logic              wbit,
  input  logic              pin_level,
  input  logic              pin_rise,
  output logic              pin_drive_low,
  output logic [DATA_W-1:0] io_rdata,
  output logic              wake_flag
);
  logic              released;
  logic              ctrl_wr, stat_wr;
  logic [DATA_W-1:0] rd_next;

  assign ctrl_wr = io_wr && (io_addr == CTRL_ADDR);
  assign stat_wr = io_wr && (io_addr == STAT_ADDR);

  always_ff @(posedge clk) begin
    if (rst)          released <= 1'b1;
    else if (ctrl_wr) released <= wbit;
  end

  always_ff @(posedge clk) begin
    if (rst) pin_drive_low <= 1'b0;
    else     pin_drive_low <= ctrl_wr ? ~wbit : ~released;
  end

  always_ff @(posedge clk) begin
    if (rst)                  wake_flag <= 1'b0;
    else if (pin_rise)        wake_flag <= 1'b1;
    else if (stat_wr && wbit) wake_flag <= 1'b0;
  end

  always_comb begin
    rd_next = '0;
    if (io_addr == CTRL_ADDR)      rd_next[0] = pin_level;
    else if (io_addr == STAT_ADDR) rd_next[0] = wake_flag;
  end

  always_ff @(posedge clk) begin
    if (rst)        io_rdata <= '0;
    else if (io_rd) io_rdata <= rd_next;
  end

  p_drive_write_r2: assert property (@(posedge clk) disable iff (rst)
    ctrl_wr |=> (pin_drive_low == ~$past(wbit)));
  p_rsvd_zero_r3: assert property (@(posedge clk) disable iff (rst)
    io_rdata[DATA_W-1:1] == '0);
  p_flag_set_r4: assert property (@(posedge clk) disable iff (rst)
    pin_rise |=> wake_flag);
  p_w1c_r5: assert property (@(posedge clk) disable iff (rst)
    (stat_wr && wbit && !pin_rise) |=> !wake_flag);
  p_other_addr_r11: assert property (@(posedge clk) disable iff (rst)
    (!ctrl_wr) |=> $stable(released));
endmodule

// File: rtl/rcw_power_fsm.sv
module rcw_power_fsm
  import rcw_pkg::*;
#(
  parameter int READY_CYCLES = 1536
) (
  input  logic clk,
  input  logic rst,
  input  logic suspend_req,
  input  logic wake_evt,
  input  logic instr_retire,
  output logic suspended,
  output logic clk_run,
  output logic core_ready,
  output logic irq_ok
);
  localparam int CNT_W = (READY_CYCLES > 1) ? $clog2(READY_CYCLES) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(READY_CYCLES - 1);

  pwr_state_t       state;
  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= PWR_RUN;
      cnt        <= '0;
      suspended  <= 1'b0;
      clk_run    <= 1'b1;
      core_ready <= 1'b1;
    end else begin
      case (state)
        PWR_RUN: if (suspend_req) begin
          state      <= PWR_SUSP;
          suspended  <= 1'b1;
          clk_run    <= 1'b0;
          core_ready <= 1'b0;
        end
        PWR_SUSP: if (wake_evt) begin
          state     <= PWR_WARM;
          suspended <= 1'b0;
          clk_run   <= 1'b1;
          cnt       <= '0;
        end
        PWR_WARM: begin
          if (cnt == LAST) begin
            state      <= PWR_RUN;
            core_ready <= 1'b1;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        default: state <= PWR_RUN;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst)                                 irq_ok <= 1'b1;
    else if (state == PWR_RUN && suspend_req) irq_ok <= 1'b0;
    else if (state != PWR_SUSP && instr_retire) irq_ok <= 1'b1;
  end

  p_susp_entry_r6: assert property (@(posedge clk) disable iff (rst)
    (!suspended && core_ready && suspend_req) |=>
      (suspended && !clk_run && !core_ready && !irq_ok));
  p_wake_r7: assert property (@(posedge clk) disable iff (rst)
    (suspended && wake_evt) |=> (!suspended && clk_run && !core_ready));
  p_ready_not_susp_r8: assert property (@(posedge clk) disable iff (rst)
    core_ready |-> !suspended);
  p_cnt_bound_r8: assert property (@(posedge clk) disable iff (rst)
    cnt <= LAST);
  p_irq_gate_r9: assert property (@(posedge clk) disable iff (rst)
    $rose(irq_ok) |-> $past(instr_retire));
endmodule

// File: rtl/rc_wake_ctrl.sv
module rc_wake_ctrl #(
  parameter int               ADDR_W       = 8,
  parameter int               DATA_W       = 8,
  parameter logic [ADDR_W-1:0] CTRL_ADDR    = 8'h22,
  parameter logic [ADDR_W-1:0] STAT_ADDR    = 8'h24,
  parameter int               SYNC_STAGES  = 2,
  parameter int               READY_CYCLES = 1536
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] io_addr,
  input  logic              io_wr,
  input  logic              io_rd,
  input  logic [DATA_W-1:0] io_wdata,
  output logic [DATA_W-1:0] io_rdata,
  input  logic              pin_in,
  output logic              pin_drive_low,
  input  logic              gpio_irq,
  input  logic              suspend_req,
  input  logic              instr_retire,
  output logic              wake_flag,
  output logic              suspended,
  output logic              clk_run,
  output logic              core_ready,
  output logic              irq_ok
);
  logic pin_level, pin_rise, wake_evt;
  logic unused_wdata;

  assign unused_wdata = ^io_wdata[DATA_W-1:1];
  assign wake_evt     = pin_rise | gpio_irq;

  rcw_sync_edge #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b1)) u_sync (
    .clk(clk), .rst(rst), .async_in(pin_in),
    .level(pin_level), .rise(pin_rise)
  );

  rcw_pin_reg #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W),
    .CTRL_ADDR(CTRL_ADDR), .STAT_ADDR(STAT_ADDR)
  ) u_reg (
    .clk(clk), .rst(rst), .io_addr(io_addr), .io_wr(io_wr), .io_rd(io_rd),
    .wbit(io_wdata[0]), .pin_level(pin_level), .pin_rise(pin_rise),
    .pin_drive_low(pin_drive_low), .io_rdata(io_rdata), .wake_flag(wake_flag)
  );

  rcw_power_fsm #(.READY_CYCLES(READY_CYCLES)) u_pwr (
    .clk(clk), .rst(rst), .suspend_req(suspend_req), .wake_evt(wake_evt),
    .instr_retire(instr_retire), .suspended(suspended), .clk_run(clk_run),
    .core_ready(core_ready), .irq_ok(irq_ok)
  );

  p_run_stable_r10: assert property (@(posedge clk) disable iff (rst)
    (core_ready && !suspend_req) |=> (core_ready && !suspended && clk_run));
endmodule

// File: tb/rc_wake_ctrl_test.sv
module rc_wake_ctrl_test;
  localparam int NREADY = 12;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [7:0] io_addr = '0;
  logic       io_wr = 1'b0, io_rd = 1'b0;
  logic [7:0] io_wdata = '0;
  logic [7:0] io_rdata;
  logic       pin_ext = 1'b1;
  logic       pin_in, pin_drive_low;
  logic       gpio_irq = 1'b0, suspend_req = 1'b0, instr_retire = 1'b0;
  logic       wake_flag, suspended, clk_run, core_ready, irq_ok;
  int         errors = 0, checks = 0;
  logic [7:0] rv;

  always #4 clk = ~clk;
  assign pin_in = pin_drive_low ? 1'b0 : pin_ext;

  rc_wake_ctrl #(.READY_CYCLES(NREADY)) uut (
    .clk(clk), .rst(rst), .io_addr(io_addr), .io_wr(io_wr), .io_rd(io_rd),
    .io_wdata(io_wdata), .io_rdata(io_rdata), .pin_in(pin_in),
    .pin_drive_low(pin_drive_low), .gpio_irq(gpio_irq),
    .suspend_req(suspend_req), .instr_retire(instr_retire),
    .wake_flag(wake_flag), .suspended(suspended), .clk_run(clk_run),
    .core_ready(core_ready), .irq_ok(irq_ok)
  );

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic check(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    io_addr = a; io_wdata = d; io_wr = 1'b1;
    step(1);
    io_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [7:0] d);
    io_addr = a; io_rd = 1'b1;
    step(1);
    io_rd = 1'b0;
    d = io_rdata;
  endtask

  task automatic t_reset;
    check("R1", "pin_drive_low", pin_drive_low, 0);
    check("R1", "suspended", suspended, 0);
    check("R1", "clk_run", clk_run, 1);
    check("R1", "core_ready", core_ready, 1);
    check("R1", "irq_ok", irq_ok, 1);
    rd(8'h22, rv); check("R1", "ctrl read", rv, 1);
    rd(8'h24, rv); check("R1", "wake flag", rv, 0);
  endtask

  task automatic t_drive;
    wr(8'h22, 8'hFE);
    check("R2", "drive after write 0", pin_drive_low, 1);
    step(2);
    rd(8'h22, rv); check("R3", "read follows pin low", rv, 0);
    wr(8'h23, 8'h01);
    check("R11", "other address keeps drive", pin_drive_low, 1);
    wr(8'h22, 8'h01);
    check("R2", "release after write 1", pin_drive_low, 0);
    step(2);
    rd(8'h22, rv); check("R3", "read follows pin high, upper bits 0", rv, 1);
    rd(8'h24, rv); check("R4", "release-induced rise sets flag", rv, 1);
    wr(8'h24, 8'h01);
  endtask

  task automatic t_pin_edge;
    pin_ext = 1'b0;
    step(4);
    rd(8'h24, rv); check("R4", "falling edge no flag", rv, 0);
    pin_ext = 1'b1;
    step(2);
    check("R4", "flag not yet after 2 edges", wake_flag, 0);
    step(1);
    check("R4", "flag on third edge", wake_flag, 1);
    check("R10", "pin rise while running keeps run", suspended, 0);
    check("R10", "core_ready kept", core_ready, 1);
    gpio_irq = 1'b1; step(1); gpio_irq = 1'b0; step(1);
    check("R10", "gpio while running keeps ready", core_ready, 1);
    check("R10", "gpio while running clk_run", clk_run, 1);
  endtask

  task automatic t_w1c;
    wr(8'h24, 8'h00);
    rd(8'h24, rv); check("R5", "write 0 keeps flag", rv, 1);
    wr(8'h24, 8'h01);
    rd(8'h24, rv); check("R5", "write 1 clears flag", rv, 0);
  endtask

  task automatic t_gpio_wake;
    suspend_req = 1'b1; step(1); suspend_req = 1'b0;
    check("R6", "suspended", suspended, 1);
    check("R6", "clk_run", clk_run, 0);
    check("R6", "core_ready", core_ready, 0);
    check("R6", "irq_ok", irq_ok, 0);
    step(5);
    check("R7", "stays suspended without wake", suspended, 1);
    gpio_irq = 1'b1; step(1); gpio_irq = 1'b0;
    check("R7", "gpio ends suspend", suspended, 0);
    check("R7", "clk_run back", clk_run, 1);
    check("R8", "not ready at wake", core_ready, 0);
    step(NREADY - 1);
    check("R8", "not ready one edge early", core_ready, 0);
    step(1);
    check("R8", "ready on count end", core_ready, 1);
    check("R9", "irq held before retire", irq_ok, 0);
    instr_retire = 1'b1; step(1); instr_retire = 1'b0;
    check("R9", "irq allowed after retire", irq_ok, 1);
  endtask

  task automatic t_pin_wake;
    pin_ext = 1'b0;
    wr(8'h22, 8'h00);
    wr(8'h22, 8'h01);
    step(3);
    suspend_req = 1'b1; step(1); suspend_req = 1'b0;
    check("R6", "suspended for pin wake", suspended, 1);
    step(3);
    pin_ext = 1'b1;
    step(2);
    check("R7", "still suspended during sync", suspended, 1);
    step(1);
    check("R7", "pin rise ends suspend", suspended, 0);
    check("R4", "pin wake sets flag", wake_flag, 1);
    step(NREADY);
    check("R8", "ready after pin wake", core_ready, 1);
    wr(8'h24, 8'h01);
    check("R5", "flag cleared", wake_flag, 0);
  endtask

  initial begin
    step(3);
    rst = 1'b0;
    step(1);
    t_reset();
    t_drive();
    t_pin_edge();
    t_w1c();
    t_gpio_wake();
    t_pin_wake();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule